// File: doc/BRIEF.md
# Corkable Word Queue with Register Access

This block is a first-in first-out queue of 32-bit words placed between a simple register bus and a pair of ready/valid streams. A host on the register bus can add a word by writing the data register and remove the oldest word by reading it. An upstream source can deliver words through a stream input, and a downstream sink can take words from a stream output. Both streams and the host share one queue.

A control register holds a single hold-off bit, the cork. While the cork is set, both stream directions stall and the host data path keeps working. Reset sets the cork. Software can therefore preload the queue, or read out what it holds, before it releases traffic. A read-only level register reports how many words the queue holds.

The register bus uses byte addresses and whole 32-bit accesses only. Read data comes back one cycle after the read strobe, together with a valid flag. Only one word can enter the queue in a cycle and only one can leave it. When the host and a stream compete for the same direction in the same cycle, the host wins and the stream handshake is withheld for that cycle. The depth parameter must be a power of two.

Top module: `corked_word_queue`

## Requirements
- R1: During reset and in the first cycle after it, the cork is set, the queue is empty, `s_ready` and `m_valid` are low, and `reg_rdata` and `reg_rvalid` are zero.
- R2: The control register sits at byte address 0x4. A write there loads bit 0 of `reg_wdata` into the cork and ignores all other bits. A read returns the cork in bit 0 and zero in every other bit.
- R3: The level register sits at byte address 0x8. A read returns the number of stored words as an unsigned value. Writes to it change nothing, and reading it does not disturb the queue.
- R4: The queue holds up to DEPTH words (64 by default), never more, and every path delivers words in the order they entered.
- R5: A write to byte address 0x0 appends `reg_wdata` when the queue is not full. When the queue is full the write is dropped and the stored words stay as they were.
- R6: A read of byte address 0x0 removes the oldest word and returns it on `reg_rdata` in the next cycle, with `reg_rvalid` high. When the queue is empty the read returns zero and changes nothing.
- R7: `s_ready` is high exactly when the cork is clear, the queue is not full, and no host data-register write is present in that cycle. Each cycle with `s_valid` and `s_ready` both high appends `s_data`.
- R8: `m_valid` is high exactly when the cork is clear, the queue is not empty, and no host data-register read is present in that cycle. `m_data` shows the oldest word, and a cycle with `m_valid` and `m_ready` both high removes it.
- R9: The host pushes and pops through the data register act the same whether the cork is set or clear.
- R10: When a word enters and another leaves in the same cycle, the level stays the same. In general the level moves by the number of words that entered minus the number that left.
- R11: A write that clears the cork takes effect from the next cycle. From then on, while `m_ready` stays high, one word leaves per cycle until the queue is empty.
- R12: Reads of any other address, or of an address whose low two bits are not zero, return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| reg_rvalid | output | 1 | High the cycle after a read strobe |
| s_valid | input | 1 | Stream input word valid |
| s_ready | output | 1 | Stream input can accept |
| s_data | input | DATA_W | Stream input word |
| m_valid | output | 1 | Stream output word valid |
| m_ready | input | 1 | Stream output sink can accept |
| m_data | output | DATA_W | Stream output word (oldest entry) |

## Verification
The bench fills the queue to its limit and then keeps writing. A design whose level counter wraps would report a small level and hand out stale words when it drains. It reads the data register on an empty queue; a design that moved its read pointer there would return old data and later duplicate or skip a word. It drives host accesses in the same cycle as stream handshakes, and pushes and pops in the same cycle. Wrong arbitration or net-level arithmetic then shows up as lost or repeated words in the drained order. It also clears the cork while the sink is already ready, to confirm that draining starts one cycle later and runs without gaps, and that the cork never lets a stream beat through.

// File: rtl/cwq_pkg.sv
package cwq_pkg;

  // Register selection decoded from the byte address
  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Word indices of the mapped registers (byte address / 4)
  localparam int unsigned IDX_DATA  = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_LEVEL = 2;

endpackage

// File: rtl/cwq_ram.sv
module cwq_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Head word is needed in the same cycle it becomes the oldest entry
  assign rdata = mem[raddr];

endmodule

// File: rtl/cwq_ctrl.sv
module cwq_ctrl #(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cork,
  input  logic             host_push_req,
  input  logic             host_pop_req,
  input  logic             s_valid,
  input  logic             m_ready,
  output logic             s_ready,
  output logic             m_valid,
  output logic             push,
  output logic             pop,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic host_push, host_pop, strm_push, strm_pop;

  assign full  = (level == LVL_MAX);
  assign empty = (level == '0);

  // Host owns the write port when it writes the data register
  assign host_push = host_push_req && !full;
  assign s_ready   = !cork && !full && !host_push_req;
  assign strm_push = s_valid && s_ready;
  assign push      = host_push || strm_push;

  // Host owns the read port when it reads the data register
  assign host_pop = host_pop_req && !empty;
  assign m_valid  = !cork && !empty && !host_pop_req;
  assign strm_pop = m_valid && m_ready;
  assign pop      = host_pop || strm_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) begin
        wptr <= wptr + PTR_ONE;
      end
      if (pop) begin
        rptr <= rptr + PTR_ONE;
      end
      unique case ({push, pop})
        2'b10:   level <= level + LVL_ONE;
        2'b01:   level <= level - LVL_ONE;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cwq_regs.sv
module cwq_regs
  import cwq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LVL_W  = 7,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              cork_wbit,
  input  logic [DATA_W-1:0] head,
  input  logic [LVL_W-1:0]  level,
  input  logic              empty,
  output logic              host_push_req,
  output logic              host_pop_req,
  output logic              cork,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);

  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (idx == IDX_W'(IDX_DATA)) begin
        sel = SEL_DATA;
      end else if (idx == IDX_W'(IDX_CTRL)) begin
        sel = SEL_CTRL;
      end else if (idx == IDX_W'(IDX_LEVEL)) begin
        sel = SEL_LEVEL;
      end
    end
  end

  assign host_push_req = reg_wr && (sel == SEL_DATA);
  assign host_pop_req  = reg_rd && (sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      cork       <= 1'b1;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_wr && (sel == SEL_CTRL)) begin
        cork <= cork_wbit;
      end
      if (reg_rd) begin
        unique case (sel)
          SEL_DATA:  reg_rdata <= empty ? '0 : head;
          SEL_CTRL:  reg_rdata <= DATA_W'(cork);
          SEL_LEVEL: reg_rdata <= DATA_W'(level);
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/corked_word_queue.sv
module corked_word_queue #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  logic             cork;
  logic             host_push_req, host_pop_req;
  logic             push, pop, full, empty;
  logic [PTR_W-1:0] wptr, rptr;
  logic [LVL_W-1:0] level;
  logic [DATA_W-1:0] head, ram_wdata;

  cwq_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .cork_wbit     (reg_wdata[0]),
    .head          (head),
    .level         (level),
    .empty         (empty),
    .host_push_req (host_push_req),
    .host_pop_req  (host_pop_req),
    .cork          (cork),
    .reg_rdata     (reg_rdata),
    .reg_rvalid    (reg_rvalid)
  );

  cwq_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cork          (cork),
    .host_push_req (host_push_req),
    .host_pop_req  (host_pop_req),
    .s_valid       (s_valid),
    .m_ready       (m_ready),
    .s_ready       (s_ready),
    .m_valid       (m_valid),
    .push          (push),
    .pop           (pop),
    .wptr          (wptr),
    .rptr          (rptr),
    .level         (level),
    .full          (full),
    .empty         (empty)
  );

  // The host has priority on the single write port
  assign ram_wdata = host_push_req ? reg_wdata : s_data;

  cwq_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (ram_wdata),
    .raddr (rptr),
    .rdata (head)
  );

  assign m_data = head;

endmodule

// File: rtl/cwq_chk.sv
module cwq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  level,
  input logic              push,
  input logic              pop,
  input logic              cork,
  input logic              full,
  input logic              empty,
  input logic              s_ready,
  input logic              m_valid,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);

  logic data_hit;
  assign data_hit = (reg_addr == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= int'(DEPTH));

  // R10
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> int'(level) == int'($past(level)) + int'($past(push)) - int'($past(pop)));

  // R5
  full_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && reg_wr && data_hit && !pop) |=> (level == $past(level)));

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && reg_rd && data_hit) |=> (reg_rdata == '0));

  // R7
  cork_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    cork |-> (!s_ready && !m_valid));

endmodule

bind corked_word_queue cwq_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .level     (level),
  .push      (push),
  .pop       (pop),
  .cork      (cork),
  .full      (full),
  .empty     (empty),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_corked_word_queue.sv
module tb_corked_word_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              reg_rvalid;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic              m_valid;
  logic              m_ready = 1'b0;
  logic [DATA_W-1:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  corked_word_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [DATA_W-1:0] q[$];
  bit                cork_m = 1'b1;
  bit                exp_rv = 1'b0;
  logic [DATA_W-1:0] exp_rd = '0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic bit is_data(input logic [ADDR_W-1:0] a);
    return a == 4'h0;
  endfunction

  // One clock: check live outputs, update model at the edge, check registered outputs
  task automatic step(input string tag);
    bit hw, hr, er, ev;
    int sz0;
    hw  = reg_wr && is_data(reg_addr);
    hr  = reg_rd && is_data(reg_addr);
    sz0 = q.size();
    er  = !cork_m && sz0 < DEPTH && !hw;
    ev  = !cork_m && sz0 > 0 && !hr;
    #1;
    chk(s_ready === er, $sformatf("R7 [%s] s_ready act=%0b exp=%0b", tag, s_ready, er));
    chk(m_valid === ev, $sformatf("R8 [%s] m_valid act=%0b exp=%0b", tag, m_valid, ev));
    if (ev) chk(m_data === q[0], $sformatf("R4 [%s] m_data act=%h exp=%h", tag, m_data, q[0]));
    @(posedge clk);
    exp_rv = reg_rd;
    if (reg_rd) begin
      case (reg_addr)
        4'h0:    exp_rd = (sz0 > 0) ? q[0] : '0;
        4'h4:    exp_rd = DATA_W'(cork_m);
        4'h8:    exp_rd = DATA_W'(sz0);
        default: exp_rd = '0;
      endcase
    end
    if (hr && sz0 > 0) void'(q.pop_front());
    else if (ev && m_ready) void'(q.pop_front());
    if (hw && sz0 < DEPTH) q.push_back(reg_wdata);
    else if (s_valid && er) q.push_back(s_data);
    if (reg_wr && reg_addr == 4'h4) cork_m = reg_wdata[0];
    @(negedge clk);
    chk(reg_rvalid === exp_rv, $sformatf("%s reg_rvalid act=%0b exp=%0b", tag, reg_rvalid, exp_rv));
    if (exp_rv) chk(reg_rdata === exp_rd, $sformatf("%s reg_rdata act=%h exp=%h", tag, reg_rdata, exp_rd));
  endtask

  task automatic host_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(tag);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [ADDR_W-1:0] a, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    step(tag);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      s_data = 32'hA000_0000 + 32'(i) + 32'(checks);
      step(tag);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    #1;
    chk(s_ready === 1'b0 && m_valid === 1'b0, $sformatf("R1 stream act=%0b%0b exp=00", s_ready, m_valid));
    chk(reg_rvalid === 1'b0 && reg_rdata === '0, $sformatf("R1 rd act=%0b/%h exp=0/0", reg_rvalid, reg_rdata));
    @(negedge clk);
    host_rd(4'h4, "R1 cork after reset");
    host_rd(4'h8, "R1 level after reset");

    // Empty data read
    host_rd(4'h0, "R6 empty read");
    host_rd(4'h8, "R6 level unchanged");

    // Host path while corked, stream offered but stalled
    s_valid = 1'b1; m_ready = 1'b1;
    host_wr(4'h0, 32'h1111_0001, "R9 corked push");
    host_wr(4'h0, 32'h1111_0002, "R9 corked push");
    host_wr(4'h0, 32'h1111_0003, "R9 corked push");
    host_wr(4'h0, 32'h1111_0004, "R9 corked push");
    idle(3, "R7 corked stream stall");
    host_rd(4'h8, "R3 level");
    host_wr(4'h8, 32'h0000_0000, "R3 level write ignored");
    host_rd(4'h8, "R3 level after write");
    host_rd(4'h0, "R9 corked pop");
    host_wr(4'hC, 32'hFFFF_FFFF, "R12 unmapped write");
    host_wr(4'h5, 32'h0000_0000, "R12 misaligned write");
    host_rd(4'hC, "R12 unmapped read");
    host_rd(4'h6, "R12 misaligned read");
    host_rd(4'h4, "R12 cork kept");

    // Release: reserved bits ignored, drain starts next cycle
    s_valid = 1'b0;
    host_wr(4'h4, 32'hFFFF_FFFE, "R11 uncork");
    host_rd(4'h4, "R2 reserved read zero");
    idle(4, "R11 continuous drain");
    host_rd(4'h8, "R11 drained level");

    // Stream in with sink stalled, then push and pop together
    m_ready = 1'b0; s_valid = 1'b1;
    idle(5, "R7 stream fill");
    m_ready = 1'b1;
    idle(6, "R10 push and pop");
    host_rd(4'h8, "R10 level steady");
    host_wr(4'h0, 32'h2222_0001, "R10 host push with egress");
    host_rd(4'h0, "R8 host pop beats egress");
    s_valid = 1'b0;
    idle(8, "R11 drain");

    // Fill past capacity while corked
    m_ready = 1'b0;
    host_wr(4'h4, 32'h0000_0001, "R2 cork set");
    for (int i = 0; i < DEPTH + 3; i++)
      host_wr(4'h0, 32'h3300_0000 + 32'(i), "R5 fill");
    host_rd(4'h8, "R5 level at full");
    s_valid = 1'b1;
    host_wr(4'h4, 32'h0000_0000, "R4 uncork at full");
    idle(2, "R4 full no ingress");
    host_rd(4'h0, "R6 pop at full");
    m_ready = 1'b1;
    idle(DEPTH + 8, "R4 drain order");
    s_valid = 1'b0;
    idle(DEPTH + 4, "R4 final drain");
    host_rd(4'h8, "R10 final level");
    finish_run();
  end

endmodule